// File: doc/BRIEF.md
# Segmented Sequential Wide Sign-Magnitude Adder

The block keeps a 2101-bit sign-magnitude running sum and adds one incoming word to it per transaction. The adder is only `SEG_W` bits wide. Each addition walks the magnitude from the least significant segment upward, one segment per clock, and holds the carry in a register between segments. With the default `SEG_W` of 421 the magnitude spans five segments. A narrower segment trades more cycles for a smaller adder: 106 bits gives about twenty cycles.

Bit 0 of every word is the sign and bits 2100..1 are the magnitude. The all-zero word is zero. A word with sign 1 and zero magnitude is NaN. A word whose magnitude bits are all ones is infinity, signed by bit 0.

When the operand signs differ, a top-down segmented compare pass finds the larger magnitude first, and the smaller magnitude is then subtracted from it. Special operands are resolved at acceptance and skip the segment passes. An operand flagged as a start of sum treats the running sum as zero, so two words can be added by sending the first with the flag set and the second without it. A clear pulse zeroes the sum and abandons any addition in flight.

Top module: `seg_wide_adder`

## Requirements
- R1: When both operands are finite with equal signs, the result magnitude is the sum of the magnitudes and the sign is kept. Carries propagate across segment boundaries.
- R2: When both operands are finite with differing signs, the result is the larger magnitude minus the smaller, and it takes the sign of the operand with the larger magnitude. Borrows propagate across segment boundaries.
- R3: A finite result of zero magnitude is always the all-zero word, with sign bit 0.
- R4: A carry out of magnitude bit 2099 (word bit 2100) in a same-sign addition saturates the result to infinity: all magnitude bits one, sign bit equal to the operands' sign.
- R5: The result is NaN (sign 1, magnitude 0) if either operand is NaN, or if the operands are infinities of opposite sign.
- R6: An infinity added to a finite operand gives that infinity unchanged.
- R7: An accepted operand with `op_start_i` high is added to zero instead of the running sum. With `op_start_i` low it is added to the running sum. The result becomes the new running sum on `res_data_o`.
- R8: An operand is accepted when `op_valid_i` and `op_ready_o` are both high at a clock edge. `busy_o` is high from the cycle after acceptance until the result is committed, and `op_ready_o` is low while `busy_o` is high. `res_valid_o` pulses for one cycle, in the first cycle in which `busy_o` is low again.
- R9: For finite operands of equal sign, `busy_o` stays high for ceil(2100/SEG_W)+1 cycles, which is 6 by default. For an operation involving NaN or infinity, `busy_o` stays high for 1 cycle.
- R10: `clear_i` zeroes `res_data_o` and drops `busy_o` by the next cycle, and abandons any addition in flight without a `res_valid_o` pulse. While `clear_i` is high, `op_ready_o` is low and no operand is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Zero the running sum and abandon any operation |
| op_valid_i | input | 1 | Operand offered |
| op_start_i | input | 1 | Operand starts a new sum (add to zero) |
| op_data_i | input | WORD_W | Operand word: bit 0 sign, upper bits magnitude |
| op_ready_o | output | 1 | Block can accept an operand this cycle |
| res_data_o | output | WORD_W | Running sum |
| res_valid_o | output | 1 | One-cycle pulse when a new sum is committed |
| busy_o | output | 1 | Addition in progress |

## Verification
Clear can collide with the operand handshake in two ways. The first case holds `clear_i` and `op_valid_i` high in the same cycle. It is judged by `op_ready_o` being low in that cycle, the sum reading zero afterwards, and no result ever appearing for the dropped operand. The second case raises `clear_i` in the middle of an addition's segment pass. It is judged by `busy_o` falling at once, the sum reading zero, and the scoreboard seeing no unexpected `res_valid_o` pulse in the following cycles. A later accumulation then confirms that the sum restarts from zero.

// File: rtl/wadd_pkg.sv
package wadd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CMP,
    ST_ADD,
    ST_FIN
  } wadd_state_e;
endpackage

// File: rtl/wadd_kind.sv
module wadd_kind #(
  parameter int unsigned WORD_W = 2101
) (
  input  logic [WORD_W-1:0] word_i,
  output logic              nan_o,
  output logic              inf_o
);
  always_comb begin
    nan_o = word_i[0] && (word_i[WORD_W-1:1] == '0);
    inf_o = &word_i[WORD_W-1:1];
  end
endmodule

// File: rtl/wadd_seg_alu.sv
module wadd_seg_alu #(
  parameter int unsigned SEG_W = 421
) (
  input  logic [SEG_W-1:0] a_i,
  input  logic [SEG_W-1:0] b_i,
  input  logic             swap_i,
  input  logic             sub_i,
  input  logic             cin_i,
  output logic [SEG_W-1:0] sum_o,
  output logic             cout_o,
  output logic             differ_o,
  output logic             b_gt_o
);
  logic [SEG_W-1:0] p, q;
  logic [SEG_W:0]   ext;

  always_comb begin
    p   = swap_i ? b_i : a_i;
    q   = swap_i ? a_i : b_i;
    // subtract as p + ~q + 1, carry held between segments means "no borrow"
    ext = {1'b0, p} + {1'b0, (sub_i ? ~q : q)} + {{SEG_W{1'b0}}, cin_i};
    sum_o    = ext[SEG_W-1:0];
    cout_o   = ext[SEG_W];
    differ_o = (a_i != b_i);
    b_gt_o   = (b_i > a_i);
  end
endmodule

// File: rtl/wadd_ctrl.sv
module wadd_ctrl
  import wadd_pkg::*;
#(
  parameter int unsigned NSEG   = 5,
  localparam int unsigned SEG_IW = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              accept_i,
  input  logic              special_i,
  input  logic              need_cmp_i,
  input  logic              cmp_hit_i,
  output wadd_state_e       state_o,
  output logic [SEG_IW-1:0] seg_o,
  output logic              busy_o
);
  localparam logic [SEG_IW-1:0] LAST = SEG_IW'(NSEG - 1);

  wadd_state_e       state_q;
  logic [SEG_IW-1:0] seg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      seg_q   <= '0;
    end else if (clear_i) begin
      state_q <= ST_IDLE;
      seg_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept_i) begin
          if (special_i) begin
            state_q <= ST_FIN;
          end else if (need_cmp_i) begin
            state_q <= ST_CMP;
            seg_q   <= LAST;
          end else begin
            state_q <= ST_ADD;
            seg_q   <= '0;
          end
        end
        ST_CMP: begin
          if (cmp_hit_i || seg_q == '0) begin
            state_q <= ST_ADD;
            seg_q   <= '0;
          end else begin
            seg_q <= seg_q - 1'b1;
          end
        end
        ST_ADD: begin
          if (seg_q == LAST) state_q <= ST_FIN;
          else               seg_q   <= seg_q + 1'b1;
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign seg_o   = seg_q;
  assign busy_o  = (state_q != ST_IDLE);

  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && !clear_i) |=> busy_o); // R8
endmodule

// File: rtl/seg_wide_adder.sv
module seg_wide_adder
  import wadd_pkg::*;
#(
  parameter int unsigned WORD_W = 2101,
  parameter int unsigned SEG_W  = 421
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              op_valid_i,
  input  logic              op_start_i,
  input  logic [WORD_W-1:0] op_data_i,
  output logic              op_ready_o,
  output logic [WORD_W-1:0] res_data_o,
  output logic              res_valid_o,
  output logic              busy_o
);
  localparam int unsigned MAG_W  = WORD_W - 1;
  localparam int unsigned NSEG   = (MAG_W + SEG_W - 1) / SEG_W;
  localparam int unsigned EXT_W  = NSEG * SEG_W;
  localparam int unsigned SEG_IW = (NSEG > 1) ? $clog2(NSEG) : 1;

  wadd_state_e       state;
  logic [SEG_IW-1:0] seg;
  logic              accept;

  logic [WORD_W-1:0] acc_q;
  logic              res_valid_q;
  logic [EXT_W-1:0]  mag_a_q, mag_b_q, sum_q;
  logic              sign_a_q, sign_b_q, sub_q, swap_q, carry_q;
  logic              sp_nan_q, sp_inf_q, sp_sign_q;

  // operand classification
  logic [WORD_W-1:0] a_word;
  logic [WORD_W-1:0] in_word [2];
  logic [1:0]        k_nan, k_inf;

  assign a_word     = op_start_i ? '0 : acc_q;
  assign in_word[0] = a_word;
  assign in_word[1] = op_data_i;

  for (genvar i = 0; i < 2; i++) begin : g_kind
    wadd_kind #(.WORD_W(WORD_W)) u_kind (
      .word_i (in_word[i]),
      .nan_o  (k_nan[i]),
      .inf_o  (k_inf[i])
    );
  end

  logic sp_nan, special, need_cmp, sp_sign;
  always_comb begin
    sp_nan   = k_nan[0] | k_nan[1] |
               (k_inf[0] & k_inf[1] & (a_word[0] != op_data_i[0]));
    special  = sp_nan | k_inf[0] | k_inf[1];
    sp_sign  = k_inf[0] ? a_word[0] : op_data_i[0];
    need_cmp = (a_word[0] != op_data_i[0]);
  end

  assign op_ready_o = (state == ST_IDLE) && !clear_i;
  assign accept     = op_valid_i && op_ready_o;

  // segment datapath
  int unsigned      seg_base;
  logic [SEG_W-1:0] seg_a, seg_b, alu_sum;
  logic             alu_cout, alu_differ, alu_b_gt;

  always_comb begin
    seg_base = int'(seg) * SEG_W;
    seg_a    = mag_a_q[seg_base +: SEG_W];
    seg_b    = mag_b_q[seg_base +: SEG_W];
  end

  wadd_seg_alu #(.SEG_W(SEG_W)) u_alu (
    .a_i      (seg_a),
    .b_i      (seg_b),
    .swap_i   (swap_q),
    .sub_i    (sub_q),
    .cin_i    (carry_q),
    .sum_o    (alu_sum),
    .cout_o   (alu_cout),
    .differ_o (alu_differ),
    .b_gt_o   (alu_b_gt)
  );

  wadd_ctrl #(.NSEG(NSEG)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (clear_i),
    .accept_i   (accept),
    .special_i  (special),
    .need_cmp_i (need_cmp),
    .cmp_hit_i  (alu_differ),
    .state_o    (state),
    .seg_o      (seg),
    .busy_o     (busy_o)
  );

  // commit word
  logic              overflow, res_sign, special_q;
  logic [WORD_W-1:0] fin_word;

  always_comb begin
    special_q = sp_nan_q | sp_inf_q;
    overflow  = !sub_q && (carry_q || ((sum_q >> MAG_W) != '0));
    res_sign  = (sub_q && swap_q) ? sign_b_q : sign_a_q;
    if (sp_nan_q)                       fin_word = {{MAG_W{1'b0}}, 1'b1};
    else if (sp_inf_q)                  fin_word = {{MAG_W{1'b1}}, sp_sign_q};
    else if (overflow)                  fin_word = {{MAG_W{1'b1}}, sign_a_q};
    else if (sum_q[MAG_W-1:0] == '0)    fin_word = '0;
    else                                fin_word = {sum_q[MAG_W-1:0], res_sign};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q       <= '0;
      res_valid_q <= 1'b0;
      mag_a_q     <= '0;
      mag_b_q     <= '0;
      sum_q       <= '0;
      sign_a_q    <= 1'b0;
      sign_b_q    <= 1'b0;
      sub_q       <= 1'b0;
      swap_q      <= 1'b0;
      carry_q     <= 1'b0;
      sp_nan_q    <= 1'b0;
      sp_inf_q    <= 1'b0;
      sp_sign_q   <= 1'b0;
    end else if (clear_i) begin
      acc_q       <= '0;
      res_valid_q <= 1'b0;
    end else begin
      res_valid_q <= (state == ST_FIN);
      unique case (state)
        ST_IDLE: if (accept) begin
          mag_a_q   <= EXT_W'(a_word[WORD_W-1:1]);
          mag_b_q   <= EXT_W'(op_data_i[WORD_W-1:1]);
          sum_q     <= '0;
          sign_a_q  <= a_word[0];
          sign_b_q  <= op_data_i[0];
          sub_q     <= need_cmp;
          swap_q    <= 1'b0;
          carry_q   <= need_cmp;
          sp_nan_q  <= sp_nan;
          sp_inf_q  <= special & ~sp_nan;
          sp_sign_q <= sp_sign;
        end
        ST_CMP: if (alu_differ) swap_q <= alu_b_gt;
        ST_ADD: begin
          sum_q[seg_base +: SEG_W] <= alu_sum;
          carry_q                  <= alu_cout;
        end
        ST_FIN:  acc_q <= fin_word;
        default: ;
      endcase
    end
  end

  assign res_data_o  = acc_q;
  assign res_valid_o = res_valid_q;

  AST_READY_LOW_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !op_ready_o); // R8
  AST_VALID_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (!busy_o && $past(busy_o))); // R8
  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (res_data_o == '0 && !busy_o && !res_valid_o)); // R10
  AST_NO_BORROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_FIN && sub_q && !special_q) |-> carry_q); // R2
  AST_INF_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_FIN && !special_q && !sub_q && carry_q && !clear_i)
      |=> (&res_data_o[WORD_W-1:1])); // R4
endmodule

// File: tb/seg_wide_adder_test.sv
module seg_wide_adder_test;
  localparam int W  = 2101;
  localparam int MW = 2100;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         clear_i = 1'b0;
  logic         op_valid_i = 1'b0;
  logic         op_start_i = 1'b0;
  logic [W-1:0] op_data_i = '0;
  logic         op_ready_o, res_valid_o, busy_o;
  logic [W-1:0] res_data_o;

  int checks = 0;
  int fails  = 0;

  logic [W-1:0] exp_q[$];
  string        tag_q[$];
  logic [W-1:0] acc_m = '0;

  always #10 clk_i = ~clk_i;

  seg_wide_adder uut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (clear_i),
    .op_valid_i  (op_valid_i),
    .op_start_i  (op_start_i),
    .op_data_i   (op_data_i),
    .op_ready_o  (op_ready_o),
    .res_data_o  (res_data_o),
    .res_valid_o (res_valid_o),
    .busy_o      (busy_o)
  );

  function automatic logic [W-1:0] mk(input logic s, input logic [MW-1:0] m);
    return {m, s};
  endfunction

  function automatic logic [W-1:0] ref_add(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [MW-1:0] ma, mb, mag;
    logic [MW:0]   s;
    logic          sa, sb, na, nb, ia, ib, sg;
    ma = a[W-1:1]; mb = b[W-1:1]; sa = a[0]; sb = b[0];
    na = sa && ma == '0; nb = sb && mb == '0;
    ia = &ma;            ib = &mb;
    if (na || nb || (ia && ib && sa != sb)) return mk(1'b1, '0);
    if (ia) return a;
    if (ib) return b;
    if (sa == sb) begin
      s = {1'b0, ma} + {1'b0, mb};
      if (s[MW]) return mk(sa, '1);
      mag = s[MW-1:0]; sg = sa;
    end else if (ma >= mb) begin
      mag = ma - mb; sg = sa;
    end else begin
      mag = mb - ma; sg = sb;
    end
    if (mag == '0) return '0;
    return mk(sg, mag);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h..%h exp=%h..%h", req, act[W-1:W-32], act[63:0],
               exp[W-1:W-32], exp[63:0]);
    end
  endtask

  task automatic chk_int(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // monitor: pops scoreboard on each result pulse
  always @(negedge clk_i) begin
    if (rst_ni && res_valid_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10 unexpected result", res_data_o, '0);
      end else begin
        logic [W-1:0] e;
        string        t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(res_data_o === e, t, res_data_o, e);
      end
    end
  end

  // driver: exp_busy < 0 skips the busy-length check
  task automatic send(input logic [W-1:0] d, input logic st, input int exp_busy,
                      input string tag);
    logic [W-1:0] e;
    int           n;
    bit           rdy_bad;
    e = ref_add(st ? '0 : acc_m, d);
    acc_m = e;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk_i);
    op_valid_i = 1'b1; op_data_i = d; op_start_i = st;
    while (!op_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    op_valid_i = 1'b0; op_start_i = 1'b0;
    n = 0; rdy_bad = 1'b0;
    while (busy_o) begin
      if (op_ready_o) rdy_bad = 1'b1;
      n++;
      @(negedge clk_i);
    end
    chk_int(!rdy_bad && n > 0, "R8 ready low while busy", int'(rdy_bad), 0);
    if (exp_busy >= 0) chk_int(n == exp_busy, "R9 busy length", n, exp_busy);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [MW-1:0] one_seg, p421, big1500, maxf, half;
    one_seg = (MW'(1) << 421) - 1'b1;
    p421    = MW'(1) << 421;
    big1500 = MW'(1) << 1500;
    maxf    = {MW{1'b1}} - 1'b1;
    half    = MW'(1) << 2099;

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // reset state: R8 R10
    chk(res_data_o == '0 && !busy_o && op_ready_o && !res_valid_o, "R10 reset state",
        res_data_o, '0);

    send(mk(1'b0, 5), 1'b1, 6, "R7 start");
    send(mk(1'b0, 7), 1'b0, 6, "R1 same sign");
    send(mk(1'b1, 20), 1'b0, -1, "R2 opposite sign");
    send(mk(1'b0, 8), 1'b0, -1, "R3 zero sign");
    send(mk(1'b0, one_seg), 1'b1, 6, "R7 restart");
    send(mk(1'b0, 1), 1'b0, 6, "R1 cross-segment carry");
    chk(res_data_o == mk(1'b0, p421), "R1 carry into segment 1", res_data_o, mk(1'b0, p421));
    send(mk(1'b1, big1500), 1'b1, -1, "R7 negative start");
    send(mk(1'b0, 1), 1'b0, 8, "R2 cross-segment borrow");
    send(mk(1'b0, maxf), 1'b1, 6, "R7 near max");
    send(mk(1'b0, 5), 1'b0, 6, "R4 positive overflow");
    send(mk(1'b1, half), 1'b1, -1, "R7 negative half");
    send(mk(1'b1, half), 1'b0, 6, "R4 negative overflow");
    send(mk(1'b0, 100), 1'b0, 1, "R6 inf plus finite");
    send(mk(1'b0, '1), 1'b0, 1, "R5 opposite infinities");
    send(mk(1'b0, 3), 1'b0, 1, "R5 nan operand a");
    send(mk(1'b0, 9), 1'b1, 6, "R7 start after nan");
    send(mk(1'b1, '0), 1'b0, 1, "R5 nan operand b");
    send(mk(1'b1, 7), 1'b1, -1, "R7 negative start");
    send(mk(1'b1, 5), 1'b0, 6, "R1 negative sign kept");
    send(mk(1'b0, 12), 1'b0, -1, "R3 cancel to zero");

    // clear during an addition in flight
    @(negedge clk_i);
    op_valid_i = 1'b1; op_data_i = mk(1'b0, 77); op_start_i = 1'b0;
    while (!op_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    op_valid_i = 1'b0;
    @(negedge clk_i);
    clear_i = 1'b1;
    @(negedge clk_i);
    clear_i = 1'b0;
    acc_m = '0;
    chk(res_data_o == '0 && !busy_o, "R10 clear mid-operation", res_data_o, '0);
    repeat (12) @(negedge clk_i);

    // clear coinciding with an operand offer
    send(mk(1'b0, 40), 1'b1, 6, "R7 before clear");
    @(negedge clk_i);
    clear_i = 1'b1; op_valid_i = 1'b1; op_data_i = mk(1'b0, 55);
    #1;
    chk_int(op_ready_o == 1'b0, "R10 ready low under clear", int'(op_ready_o), 0);
    @(negedge clk_i);
    clear_i = 1'b0; op_valid_i = 1'b0;
    acc_m = '0;
    chk(res_data_o == '0 && !busy_o, "R10 offer dropped", res_data_o, '0);
    repeat (12) @(negedge clk_i);

    send(mk(1'b0, 4), 1'b0, 6, "R10 accumulates from zero");
    repeat (4) @(negedge clk_i);
    chk_int(exp_q.size() == 0, "R8 all results delivered", exp_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule